// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a 12-bit serially programmed DAC. It watches four serial pins: an active-low chip select, a frame sync, a serial clock and a data line. All four are oversampled by a faster system clock. A falling edge on frame sync opens a 16-bit command frame. Data bits are taken most significant first, one on each falling edge of the serial clock.

A frame is committed when its sixteenth bit arrives, or earlier when frame sync rises. At commit, the 4-bit header picks a target.
- A DAC-code write updates the 12-bit code held for the converter and pulses an update strobe.
- A control write updates the 2-bit reference selector.
- Both kinds of accepted write also load the speed and power-down mode bits carried in the header.

The block works in four-wire use, where chip select is driven per device, and in three-wire use, where chip select is tied low.

Top module: `sdac_cmd_rx`

## Requirements
- R1: After reset, `dac_code`, `ref_sel`, `fast_mode`, `pwr_down` and `code_strobe` are all zero.
- R2: While `csn_pin` is high, no frame is started or received, and none of the held outputs change.
- R3: A falling edge on `fsync_pin` starts a frame. Bits are shifted in MSB first (the first bit is D15), one per falling `sclk_pin` edge. When the 16th bit arrives, a word whose header has D15=0 and D12=0 loads D11..D0 into `dac_code`.
- R4: `code_strobe` is high for exactly one system clock cycle, in the cycle in which `dac_code` takes a new value. It pulses on each DAC-code write and on no other frame.
- R5: A word with D15=1 and D12=1 is a control write. It loads D1:D0 into `ref_sel`, where 00 and 11 mean external, 01 means internal low and 10 means internal high. It ignores D11..D2 and leaves `dac_code` unchanged.
- R6: Every accepted DAC-code or control write loads `fast_mode` from D14 and `pwr_down` from D13.
- R7: A word whose header has D15≠D12 (codes 01 and 10) is discarded. It changes no output and raises no strobe.
- R8: If `fsync_pin` rises after n bits, with 1 ≤ n < 16, the n bits are committed left-aligned from D15, with the missing low bits taken as zero. If it rises with no bits received, nothing is committed.
- R9: Falling serial clock edges after the 16th bit of a frame are ignored until the next frame-sync falling edge.
- R10: With `csn_pin` held low permanently, back-to-back frames are each received and committed (three-wire use).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_pin | input | 1 | Serial clock pin; data sampled on its falling edge |
| fsync_pin | input | 1 | Frame sync pin; falling edge opens a frame, rising edge ends it early |
| csn_pin | input | 1 | Active-low chip select |
| sdin_pin | input | 1 | Serial data pin |
| dac_code | output | 12 | Held converter code |
| ref_sel | output | 2 | Reference source select |
| fast_mode | output | 1 | 1 = fast settling, 0 = slow |
| pwr_down | output | 1 | 1 = power-down requested |
| code_strobe | output | 1 | One-cycle pulse when a new code is committed |

## Verification
The assertions take for granted that the serial pins stay slow relative to the system clock. Every level of `sclk_pin` must last at least two system cycles. `sdin_pin` must be steady around each falling serial edge, so that the synchronized data bit and clock edge line up, and chip select must settle before frame sync falls. The stimulus holds each serial clock level for four system cycles and changes data only while the serial clock is high. It also changes chip select several cycles before any frame edge. Under these conditions, the checker's rules hold at every cycle: code changes only with a strobe, no update while deselected, and a reference change never coincides with a strobe.

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx #(
  parameter int WORD_W = 16,
  parameter int DATA_W = 12,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_pin,
  input  logic              fsync_pin,
  input  logic              csn_pin,
  input  logic              sdin_pin,
  output logic [DATA_W-1:0] dac_code,
  output logic [1:0]        ref_sel,
  output logic              fast_mode,
  output logic              pwr_down,
  output logic              code_strobe
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int NPIN  = 4;
  localparam int H_R1  = WORD_W - 1;
  localparam int H_SPD = WORD_W - 2;
  localparam int H_PWR = WORD_W - 3;
  localparam int H_R0  = WORD_W - 4;

  logic [SYNC_N*NPIN-1:0] sy;
  logic [NPIN-1:0]        pins_s, pins_d;
  logic                   sclk_s, fs_s, cs_s, din_s;
  logic                   sclk_d, fs_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy     <= '0;
      pins_d <= '0;
    end else begin
      sy     <= {sy[(SYNC_N-1)*NPIN-1:0], sclk_pin, fsync_pin, csn_pin, sdin_pin};
      pins_d <= pins_s;
    end

  assign pins_s = sy[SYNC_N*NPIN-1 -: NPIN];
  assign {sclk_s, fs_s, cs_s, din_s} = pins_s;
  assign sclk_d = pins_d[3];
  assign fs_d   = pins_d[2];

  wire sel_on    = ~cs_s;
  wire sclk_fall = sclk_d & ~sclk_s;
  wire fs_fall   = fs_d & ~fs_s;
  wire fs_rise   = ~fs_d & fs_s;

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;

  wire                shift_en = active & sclk_fall;
  wire [CNT_W-1:0]    nxt_cnt  = cnt + CNT_W'(shift_en);
  wire [WORD_W-1:0]   nxt_sh   = shift_en ? {sh[WORD_W-2:0], din_s} : sh;
  wire                full     = nxt_cnt == CNT_W'(WORD_W);
  wire                early    = fs_rise & (nxt_cnt != '0);
  wire                commit   = sel_on & active & ~fs_fall & (full | early);
  wire [CNT_W-1:0]    pad      = CNT_W'(WORD_W) - nxt_cnt;
  wire [WORD_W-1:0]   word     = nxt_sh << pad;
  wire [1:0]          target   = {word[H_R1], word[H_R0]};
  wire                dac_wr   = commit & (target == 2'b00);
  wire                ctl_wr   = commit & (target == 2'b11);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else if (!sel_on) begin
      active <= 1'b0;
    end else if (fs_fall) begin
      active <= 1'b1;
      cnt    <= '0;
      sh     <= '0;
    end else if (active) begin
      cnt <= nxt_cnt;
      sh  <= nxt_sh;
      if (full || fs_rise) active <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dac_code    <= '0;
      ref_sel     <= '0;
      fast_mode   <= 1'b0;
      pwr_down    <= 1'b0;
      code_strobe <= 1'b0;
    end else begin
      code_strobe <= dac_wr;
      if (dac_wr) dac_code <= word[DATA_W-1:0];
      if (ctl_wr) ref_sel  <= word[1:0];
      if (dac_wr || ctl_wr) begin
        fast_mode <= word[H_SPD];
        pwr_down  <= word[H_PWR];
      end
    end
endmodule

module sdac_cmd_rx_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic [DATA_W-1:0] dac_code,
  input logic [1:0]        ref_sel,
  input logic              fast_mode,
  input logic              pwr_down,
  input logic              code_strobe
);
  assert_rst_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dac_code == '0 && ref_sel == 2'b00 && !fast_mode && !pwr_down && !code_strobe));

  assert_deselect_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable({dac_code, ref_sel, fast_mode, pwr_down}));

  assert_code_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> code_strobe);

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    code_strobe |=> !code_strobe);

  assert_ref_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel != $past(ref_sel)) |-> !code_strobe);
endmodule

bind sdac_cmd_rx sdac_cmd_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .dac_code(dac_code), .ref_sel(ref_sel),
  .fast_mode(fast_mode), .pwr_down(pwr_down), .code_strobe(code_strobe));

// File: tb/sdac_cmd_rx_tb_top.sv
module sdac_cmd_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_pin = 1'b1, fsync_pin = 1'b1, csn_pin = 1'b1, sdin_pin = 1'b0;
  logic [11:0] dac_code;
  logic [1:0]  ref_sel;
  logic        fast_mode, pwr_down, code_strobe;

  int checks = 0, errors = 0, strobes = 0;
  bit done = 0;
  logic [11:0] exp_q[$];
  logic [11:0] e_code = '0;
  logic [1:0]  e_ref = '0;
  logic        e_fast = 0, e_pwr = 0;

  always #4 clk = ~clk;

  sdac_cmd_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .fsync_pin(fsync_pin),
    .csn_pin(csn_pin), .sdin_pin(sdin_pin), .dac_code(dac_code), .ref_sel(ref_sel),
    .fast_mode(fast_mode), .pwr_down(pwr_down), .code_strobe(code_strobe));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: every strobe pops one expected code (R3, R4)
  always @(negedge clk) if (rst_n && code_strobe) begin
    strobes++;
    if (exp_q.size() == 0) check("R4 unexpected strobe", 1, 0);
    else check("R3 strobed code", dac_code, exp_q.pop_front());
  end

  // Driver: models the expected outcome, then drives the pins.
  // D15=R1, D14=fast, D13=power-down, D12=R0, D11..D0 data.
  task automatic send_frame(logic [15:0] w, int nb, logic csn_v);
    int eff = nb > 16 ? 16 : nb;
    logic [15:0] aw;
    if (!csn_v && eff > 0) begin
      aw = (w >> (16 - eff)) << (16 - eff);
      if (!aw[15] && !aw[12]) begin
        e_code = aw[11:0]; e_fast = aw[14]; e_pwr = aw[13];
        exp_q.push_back(aw[11:0]);
      end else if (aw[15] && aw[12]) begin
        e_ref = aw[1:0]; e_fast = aw[14]; e_pwr = aw[13];
      end
    end
    @(negedge clk) csn_pin = csn_v;
    repeat (4) @(negedge clk);
    fsync_pin = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sdin_pin = (i < 16) ? w[15-i] : i[0];
      repeat (4) @(negedge clk);
      sclk_pin = 1'b0;
      repeat (4) @(negedge clk);
      sclk_pin = 1'b1;
    end
    repeat (4) @(negedge clk);
    fsync_pin = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    check({tag, " dac_code"}, dac_code, e_code);
    check({tag, " ref_sel"}, ref_sel, e_ref);
    check({tag, " fast_mode"}, fast_mode, e_fast);
    check({tag, " pwr_down"}, pwr_down, e_pwr);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    int s0;
    repeat (5) @(negedge clk);
    check_all("R1 reset");
    check("R1 strobe", code_strobe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R1 after release");

    s0 = strobes;
    send_frame(16'hD002, 16, 1'b0);
    check_all("R5 control write");
    check("R4 no strobe on control", strobes, s0);

    send_frame(16'h4ABC, 16, 1'b0);
    check_all("R3 dac write fast");
    send_frame(16'h0123, 16, 1'b0);
    check_all("R6 dac write slow");

    send_frame(16'hB001, 16, 1'b0);
    check_all("R6 control power-down");

    s0 = strobes;
    send_frame(16'h8FFF, 16, 1'b0);
    check_all("R7 reserved 10");
    send_frame(16'h1555, 16, 1'b0);
    check_all("R7 reserved 01");
    check("R7 no strobe", strobes, s0);

    send_frame(16'h4FFF, 16, 1'b1);
    check_all("R2 deselected");
    check("R2 no strobe", strobes, s0);

    send_frame(16'h0AB3, 8, 1'b0);
    check_all("R8 partial 8 bits");
    s0 = strobes;
    send_frame(16'h4777, 0, 1'b0);
    check_all("R8 zero bits");
    check("R8 zero bits no strobe", strobes, s0);
    send_frame(16'hD0F3, 13, 1'b0);
    check_all("R8 partial control");

    send_frame(16'h07FF, 20, 1'b0);
    check_all("R9 extra clocks ignored");

    send_frame(16'h4001, 16, 1'b0);
    send_frame(16'h0FFE, 16, 1'b0);
    check_all("R10 back to back");
    send_frame(16'hDFFC, 16, 1'b0);
    check_all("R5 don't-care bits");

    repeat (10) @(negedge clk);
    check("R4 all strobes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule